// File: doc/BRIEF.md
# Branch Delay-Slot Quash Controller

This block sits between issue and writeback in an in-order core that issues two instructions per cycle. A branch takes two cycles to resolve. The two issue bundles that follow it are its delay slots, and they are issued with no stall. The block tags those two bundles as they go down a fixed-latency writeback pipe. When the branch test arrives, it marks both bundles as kept or discarded. The choice follows a two-bit quash mode carried by the branch.

Every issue bundle reaches the commit point a fixed `COMMIT_LAT` cycles after it is issued. At that point it drives either per-lane commit enables or per-lane quash flags. A quashed bundle still flows down the pipe, but its lanes never raise a commit. When the test is true, the block sends a one-cycle redirect with the branch target. That redirect comes once the second delay slot has issued. A branch that appears inside a delay slot is not started as a branch. It is an ordinary slot instruction and shares its slot's fate.

Top module: `dslot_quash_ctrl`

## Requirements
- R1: In the first cycle after a synchronous active-high reset, `commitEn`, `quashEn` and `redirectValid` are all zero.
- R2: A bundle issued in cycle c outside any delay slot shows `commitEn` equal to its `issueValid` lanes in cycle c+COMMIT_LAT, with `quashEn` zero.
- R3: Mode 2'b00 commits both delay-slot bundles whatever the test value.
- R4: Mode 2'b01 commits both delay-slot bundles when the test is 1 and quashes them when it is 0.
- R5: Mode 2'b10 commits both delay-slot bundles when the test is 0 and quashes them when it is 1.
- R6: Mode 2'b11 quashes both delay-slot bundles whatever the test value.
- R7: Both lanes of a delay-slot bundle share one decision. A quashed bundle shows its `issueValid` lanes on `quashEn` and none on `commitEn`, and the two outputs are never high on the same lane.
- R8: A branch is accepted in cycle b. Its delay slots are cycles b+1 and b+2, and its test is sampled in cycle b+2. If that test is 1, `redirectValid` is high for exactly cycle b+3, with `redirectTarget` equal to the target given in cycle b. If the test is 0, there is no redirect.
- R9: `brValid` in a delay-slot cycle starts no branch, causes no redirect, and leaves that bundle under the enclosing branch's decision.
- R10: `brTest` is ignored in every cycle except the second delay slot of an accepted branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issueValid | input | LANES | Per-lane valid of the bundle issued this cycle |
| brValid | input | 1 | This bundle carries a branch |
| brMode | input | 2 | Quash mode of the branch |
| brTarget | input | ADDR_W | Branch target address |
| brTest | input | 1 | Branch test outcome, used in the second delay-slot cycle |
| commitEn | output | LANES | Per-lane commit enable at the writeback point |
| quashEn | output | LANES | Per-lane flag: lane reached writeback but was discarded |
| redirectValid | output | 1 | One-cycle fetch redirect strobe |
| redirectTarget | output | ADDR_W | Address to load into the fetch pointer |

## Verification
Resolution and commit can fall in the same cycle. On the edge where a branch resolves, the second slot bundle enters the pipe already decided. The first slot bundle, still pending, is decided as it moves between stages. In that same cycle an older, unrelated bundle may be leaving the pipe. Back-to-back branches provoke this overlap, as do branches issued inside delay slots and randomly asserted test values. A behavioural reference model computes the expected commit, quash and redirect for every cycle, and the bench compares them on every clock. That shows whether each bundle was decided under the right branch.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

  typedef enum logic [1:0] {
    QM_KEEP           = 2'b00,
    QM_KEEP_TAKEN     = 2'b01,
    QM_KEEP_NOT_TAKEN = 2'b10,
    QM_DISCARD        = 2'b11
  } qmode_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SLOT1 = 2'd1,
    PH_SLOT2 = 2'd2
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic inSlot;   // bundle issued this cycle is a delay slot
    logic resolve;  // branch decision is known this cycle
    logic keep;     // decision: 1 commit the slots, 0 quash them
  } qcStrobe_t;

endpackage

// File: rtl/dslot_ctrl.sv
module dslot_ctrl
  import dslot_pkg::*;
#(
  parameter int ADDR_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              brValid,
  input  logic [1:0]        brMode,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic              brTest,
  output qcStrobe_t         strobe,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectTarget
);

  phase_t            phase;
  qmode_t            modeQ;
  logic [ADDR_W-1:0] targetQ;
  logic              keepDecision;

  always_comb begin
    unique case (modeQ)
      QM_KEEP:           keepDecision = 1'b1;
      QM_KEEP_TAKEN:     keepDecision = brTest;
      QM_KEEP_NOT_TAKEN: keepDecision = ~brTest;
      default:           keepDecision = 1'b0;
    endcase
  end

  always_comb begin
    strobe.inSlot  = (phase != PH_IDLE);
    strobe.resolve = (phase == PH_SLOT2);
    strobe.keep    = keepDecision;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase          <= PH_IDLE;
      modeQ          <= QM_KEEP;
      targetQ        <= '0;
      redirectValid  <= 1'b0;
      redirectTarget <= '0;
    end else begin
      redirectValid <= (phase == PH_SLOT2) && brTest;
      if ((phase == PH_SLOT2) && brTest) redirectTarget <= targetQ;
      unique case (phase)
        PH_IDLE: begin
          if (brValid) begin
            phase   <= PH_SLOT1;
            modeQ   <= qmode_t'(brMode);
            targetQ <= brTarget;
          end
        end
        PH_SLOT1: phase <= PH_SLOT2;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  assert_reset_redirect_R1: assert property (@(posedge clk)
    rst |=> !redirectValid);

  assert_redirect_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    redirectValid |=> !redirectValid);

  assert_no_nested_R9: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> (phase != PH_SLOT1));

  assert_test_window_R10: assert property (@(posedge clk) disable iff (rst)
    redirectValid |-> ($past(phase) == PH_SLOT2 && $past(brTest)));

endmodule

// File: rtl/dslot_data.sv
module dslot_data
  import dslot_pkg::*;
#(
  parameter int LANES      = 2,
  parameter int COMMIT_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] issueValid,
  input  qcStrobe_t        strobe,
  output logic [LANES-1:0] commitEn,
  output logic [LANES-1:0] quashEn
);

  localparam int LAST = COMMIT_LAT - 1;

  logic [COMMIT_LAT-1:0][LANES-1:0] stLanes;
  logic [COMMIT_LAT-1:0]            stPend;
  logic [COMMIT_LAT-1:0]            stKeep;

  always_ff @(posedge clk) begin
    if (rst) begin
      stLanes <= '0;
      stPend  <= '0;
      stKeep  <= '0;
    end else begin
      stLanes[0] <= issueValid;
      stPend[0]  <= strobe.inSlot & ~strobe.resolve;
      stKeep[0]  <= ~strobe.inSlot | (strobe.resolve & strobe.keep);
      for (int s = 1; s < COMMIT_LAT; s++) begin
        stLanes[s] <= stLanes[s-1];
        if (strobe.resolve && stPend[s-1]) begin
          stPend[s] <= 1'b0;
          stKeep[s] <= strobe.keep;
        end else begin
          stPend[s] <= stPend[s-1];
          stKeep[s] <= stKeep[s-1];
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign commitEn[l] = stLanes[LAST][l] &  stKeep[LAST];
    assign quashEn[l]  = stLanes[LAST][l] & ~stKeep[LAST];
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (commitEn == '0 && quashEn == '0));

  assert_decided_at_commit_R7: assert property (@(posedge clk) disable iff (rst)
    (stLanes[LAST] != '0) |-> !stPend[LAST]);

endmodule

// File: rtl/dslot_quash_ctrl.sv
module dslot_quash_ctrl
  import dslot_pkg::*;
#(
  parameter int LANES      = 2,
  parameter int ADDR_W     = 40,
  parameter int COMMIT_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  issueValid,
  input  logic              brValid,
  input  logic [1:0]        brMode,
  input  logic [ADDR_W-1:0] brTarget,
  input  logic              brTest,
  output logic [LANES-1:0]  commitEn,
  output logic [LANES-1:0]  quashEn,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectTarget
);

  qcStrobe_t strobe;

  dslot_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .brValid        (brValid),
    .brMode         (brMode),
    .brTarget       (brTarget),
    .brTest         (brTest),
    .strobe         (strobe),
    .redirectValid  (redirectValid),
    .redirectTarget (redirectTarget)
  );

  dslot_data #(.LANES(LANES), .COMMIT_LAT(COMMIT_LAT)) u_data (
    .clk        (clk),
    .rst        (rst),
    .issueValid (issueValid),
    .strobe     (strobe),
    .commitEn   (commitEn),
    .quashEn    (quashEn)
  );

endmodule

// File: tb/dslot_quash_ctrl_test.sv
module dslot_quash_ctrl_test;

  localparam int LANES  = 2;
  localparam int ADDR_W = 40;
  localparam int LAT    = 3;
  localparam int NCYC   = 3000;
  localparam int NARR   = NCYC + 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [LANES-1:0]  issueValid = '0;
  logic              brValid = 1'b0;
  logic [1:0]        brMode = 2'b00;
  logic [ADDR_W-1:0] brTarget = '0;
  logic              brTest = 1'b0;
  logic [LANES-1:0]  commitEn, quashEn;
  logic              redirectValid;
  logic [ADDR_W-1:0] redirectTarget;

  always #5 clk = ~clk;

  dslot_quash_ctrl #(.LANES(LANES), .ADDR_W(ADDR_W), .COMMIT_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .issueValid(issueValid), .brValid(brValid),
    .brMode(brMode), .brTarget(brTarget), .brTest(brTest),
    .commitEn(commitEn), .quashEn(quashEn),
    .redirectValid(redirectValid), .redirectTarget(redirectTarget)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model storage, indexed by issue cycle
  int                expC   [NARR];
  int                expQ   [NARR];
  int                ivArr  [NARR];
  bit                expRed [NARR];
  logic [ADDR_W-1:0] expTgt [NARR];
  string             tagC   [NARR];
  string             tagR   [NARR];
  bit                slotBr [NARR];

  int                ph = 0;
  int                bmode = 0;
  logic [ADDR_W-1:0] btgt = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit keepOf(input int m, input bit t);
    case (m)
      0: return 1'b1;
      1: return t;
      2: return !t;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string modeTag(input int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // model one issue cycle n with the inputs just driven
  task automatic modelStep(input int n, input int iv, input bit bv, input int md,
                           input logic [ADDR_W-1:0] tg, input bit tst);
    ivArr[n] = iv;
    tagR[n+1] = (tst && ph != 2) ? "R10" : "R8";
    case (ph)
      0: begin
        expC[n] = iv; expQ[n] = 0; tagC[n] = "R2";
        if (bv) begin ph = 1; bmode = md; btgt = tg; end
      end
      1: begin
        slotBr[n] = bv; ph = 2;
      end
      default: begin
        slotBr[n] = bv;
        for (int k = n - 1; k <= n; k++) begin
          bit kp = keepOf(bmode, tst);
          expC[k] = kp ? ivArr[k] : 0;
          expQ[k] = kp ? 0 : ivArr[k];
          tagC[k] = slotBr[k] ? "R9" : modeTag(bmode);
        end
        if (tst) begin expRed[n+1] = 1'b1; expTgt[n+1] = btgt; end
        ph = 0;
      end
    endcase
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < NARR; i++) begin
      expC[i] = 0; expQ[i] = 0; ivArr[i] = 0; expRed[i] = 0; expTgt[i] = '0;
      tagC[i] = "R2"; tagR[i] = "R8"; slotBr[i] = 0;
    end
    repeat (3) @(negedge clk);
    // first cycle after reset
    check(commitEn == '0, "R1", "commitEn after reset", commitEn, 0);
    check(quashEn == '0, "R1", "quashEn after reset", quashEn, 0);
    check(!redirectValid, "R1", "redirectValid after reset", redirectValid, 0);
    rst = 1'b0;
    for (int n = 0; n < NCYC; n++) begin
      int iv; bit bv; int md; logic [ADDR_W-1:0] tg; bit tst;
      if (n > 0) @(negedge clk);
      // compare outputs of cycle n
      if (n >= LAT) begin
        check(commitEn == LANES'(expC[n-LAT]), tagC[n-LAT], "commitEn",
              commitEn, expC[n-LAT]);
        check(quashEn == LANES'(expQ[n-LAT]), (tagC[n-LAT] == "R2") ? "R2" : "R7",
              "quashEn", quashEn, expQ[n-LAT]);
      end else begin
        check(commitEn == '0 && quashEn == '0, "R1", "idle pipe", {commitEn, quashEn}, 0);
      end
      check((commitEn & quashEn) == '0, "R7", "lane exclusive", commitEn & quashEn, 0);
      check(redirectValid == expRed[n], tagR[n], "redirectValid", redirectValid, expRed[n]);
      if (expRed[n])
        check(redirectTarget == expTgt[n], "R8", "redirectTarget", redirectTarget, expTgt[n]);
      // choose stimulus for cycle n
      iv = $urandom_range(0, 3);
      tg = {$urandom, $urandom};
      if (n < 128) begin
        bv  = (n % 4 == 0) || (n % 8 == 1);
        md  = (n / 4) % 4;
        tst = ((n / 16) % 2) == 1;
      end else if (n >= NCYC - 8) begin
        bv = 0; md = 0; tst = 0; iv = 0;
      end else begin
        bv  = $urandom_range(0, 9) < 4;
        md  = $urandom_range(0, 3);
        tst = $urandom_range(0, 1) == 1;
      end
      issueValid = LANES'(iv); brValid = bv; brMode = 2'(md);
      brTarget = tg; brTest = tst;
      modelStep(n, iv, bv, md, tg, tst);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule